// File: doc/BRIEF.md
# Interleaved Character Screen Fetch and Attribute Decoder

This block sits in a display pipeline for a 256x192 screen stored at one bit per pixel. The pixel lines are interleaved in memory, and colour comes from attribute bytes. Each beam position (X 0-255, Y 0-191) is turned into two byte addresses: the pixel byte and the attribute byte that colours it. Both addresses come from registers. The memory returns the two bytes. The block then decodes them, together with the pixel position inside the byte, into an 8-bit palette index.

Attributes can be addressed in two ways:
- **Cell mode:** one attribute byte for each 8x8 cell, laid out in plain row order.
- **Line mode:** one attribute byte for each 8x1 strip, using the same interleaved layout as the pixels.

Attributes can be interpreted in two ways:
- **Classic:** 3-bit ink and paper, with bright and flash bits.
- **Enhanced:** an ink mask splits the attribute byte into an ink palette index and a paper palette index.

The control inputs are sampled together with the beam position, so they stay aligned with the bytes they apply to.

Top module: `cscr_fetch_decode`

## Requirements
- R1: One clock after the beam is sampled, `pix_addr` equals {2'b01, S, Y[7:6], Y[2:0], Y[5:3], X[7:3]} (bit 15 first). S is the screen-select bit defined in R3 and R4.
- R2: In cell mode (`line_attr`=0), one clock after sampling, `attr_addr` equals 0x5800 + S*0x2000 + (Y/8)*32 + X/8.
- R3: In cell mode, S equals `scr_alt`. Setting `scr_alt` therefore adds 0x2000 to both addresses.
- R4: In line mode (`line_attr`=1), `scr_alt` is ignored and S is 0. `attr_addr` equals `pix_addr` + 0x2000.
- R5: The lit bit of the pixel is `pix_byte`[7 - X[2:0]], so the leftmost pixel is the MSB. The bytes are taken in the cycle in which their addresses are shown. `color_idx` is valid one clock after that, which is two clocks after the beam is sampled.
- R6: In classic mode (`enh_en`=0), ink is attribute[2:0], paper is attribute[5:3] and bright is attribute[6]. The index is bright*8 + (lit ? ink : paper), so it is always below 16.
- R7: In classic mode, when attribute[7] (flash) is 1 and `flash_phase` is 1, the roles of ink and paper are swapped.
- R8: In enhanced mode, let k be the number of ones in the ink mask. A lit pixel gives attribute AND ((1<<k)-1). A mask is meant to be a contiguous run of ones from bit 0.
- R9: In enhanced mode with k < 8, an unlit pixel gives 128 + (attribute >> k). The bright and flash bits and `flash_phase` have no effect in this mode.
- R10: In enhanced mode with k = 8, an unlit pixel gives `paper_fallback`.
- R11: An all-zero ink mask behaves exactly like an all-ones mask.
- R12: While `rst_n` is low, `pix_addr`, `attr_addr` and `color_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| beam_x | input | 8 | Beam column, 0-255 |
| beam_y | input | 8 | Beam line, 0-191 |
| scr_alt | input | 1 | Alternate screen select (cell mode only) |
| line_attr | input | 1 | 1: 8x1 line attributes; 0: 8x8 cell attributes |
| enh_en | input | 1 | Enhanced attribute interpretation |
| ink_mask | input | 8 | Ink field mask for enhanced mode |
| flash_phase | input | 1 | Flash phase; 1 swaps colours of flashing cells |
| paper_fallback | input | 8 | Paper index used when the whole attribute is ink |
| pix_byte | input | 8 | Fetched pixel byte |
| attr_byte | input | 8 | Fetched attribute byte |
| pix_addr | output | 16 | Pixel byte address |
| attr_addr | output | 16 | Attribute byte address |
| color_idx | output | 8 | Palette index of the current pixel |

## Verification
Both addresses are due one clock after the beam and controls are driven. The colour index is due one clock after the fetched bytes are presented, which is two clocks after the beam. The bench drives stimulus and samples outputs on the falling edge. It keeps a two-deep record of earlier stimulus so that each address check uses the beam of the previous cycle. Each colour check uses the beam, controls and bytes from two cycles earlier. The fetched bytes come from a behavioural memory that the bench indexes with its own expected addresses, never with the outputs of the design.

// File: rtl/cscr_pkg.sv
package cscr_pkg;
  localparam int COORD_W = 8;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 16;
  localparam int SEL_W   = 3;
  localparam int CNT_W   = 4;

  localparam logic [1:0] BANK_TOP     = 2'b01;
  localparam logic [2:0] CELL_ATTR_HI = 3'b110;
  localparam logic [ADDR_W-1:0] ALT_OFS = 16'h2000;
  localparam logic [BYTE_W-1:0] PAPER_BASE = 8'h80;

  typedef struct packed {
    logic [SEL_W-1:0]  bit_sel;
    logic              enh;
    logic [BYTE_W-1:0] ink_mask;
    logic              phase;
    logic [BYTE_W-1:0] fallback;
  } dec_ctl_t;
endpackage

// File: rtl/cscr_addr_gen.sv
module cscr_addr_gen
  import cscr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic               alt,
  input  logic               line_mode,
  output logic [ADDR_W-1:0]  pix_addr,
  output logic [ADDR_W-1:0]  attr_addr
);
  logic              alt_eff;
  logic [ADDR_W-1:0] pix_d;
  logic [ADDR_W-1:0] attr_d;

  always_comb begin
    alt_eff = alt & ~line_mode;
    // third / line-in-cell / cell-row / byte column
    pix_d = {BANK_TOP, alt_eff, y[7:6], y[2:0], y[5:3], x[7:3]};
    if (line_mode) begin
      attr_d = pix_d | ALT_OFS;
    end else begin
      attr_d = {BANK_TOP, alt_eff, CELL_ATTR_HI, y[7:3], x[7:3]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_addr  <= '0;
      attr_addr <= '0;
    end else begin
      pix_addr  <= pix_d;
      attr_addr <= attr_d;
    end
  end
endmodule

// File: rtl/cscr_mask_norm.sv
module cscr_mask_norm
  import cscr_pkg::*;
(
  input  logic [BYTE_W-1:0] mask,
  output logic [BYTE_W-1:0] keep,
  output logic [CNT_W-1:0]  ink_bits,
  output logic              all_ink
);
  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      ones = ones + CNT_W'(mask[i]);
    end
    ink_bits = (ones == '0) ? CNT_W'(BYTE_W) : ones;
    all_ink  = (ink_bits == CNT_W'(BYTE_W));
  end

  for (genvar g = 0; g < BYTE_W; g++) begin : g_keep
    assign keep[g] = (ink_bits > CNT_W'(g));
  end
endmodule

// File: rtl/cscr_attr_decode.sv
module cscr_attr_decode
  import cscr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  dec_ctl_t          ctl_d,
  input  logic [BYTE_W-1:0] pix_byte,
  input  logic [BYTE_W-1:0] attr_byte,
  output logic [BYTE_W-1:0] color_idx
);
  dec_ctl_t          ctl_q;
  logic [BYTE_W-1:0] keep;
  logic [CNT_W-1:0]  ink_bits;
  logic              all_ink;
  logic              lit;
  logic              swap;
  logic              on_ink;
  logic [BYTE_W-1:0] std_idx;
  logic [BYTE_W-1:0] enh_ink;
  logic [BYTE_W-1:0] enh_paper;
  logic [BYTE_W-1:0] color_d;

  cscr_mask_norm u_norm (
    .mask     (ctl_q.ink_mask),
    .keep     (keep),
    .ink_bits (ink_bits),
    .all_ink  (all_ink)
  );

  always_comb begin
    lit     = pix_byte[SEL_W'(BYTE_W - 1) - ctl_q.bit_sel];
    swap    = attr_byte[7] & ctl_q.phase;
    on_ink  = lit ^ swap;
    std_idx = {4'b0000, attr_byte[6], on_ink ? attr_byte[2:0] : attr_byte[5:3]};
    enh_ink   = attr_byte & keep;
    enh_paper = all_ink ? ctl_q.fallback : (PAPER_BASE + (attr_byte >> ink_bits));
    if (ctl_q.enh) begin
      color_d = lit ? enh_ink : enh_paper;
    end else begin
      color_d = std_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      color_idx <= '0;
    end else begin
      ctl_q     <= ctl_d;
      color_idx <= color_d;
    end
  end
endmodule

// File: rtl/cscr_fetch_decode.sv
module cscr_fetch_decode
  import cscr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] beam_x,
  input  logic [COORD_W-1:0] beam_y,
  input  logic               scr_alt,
  input  logic               line_attr,
  input  logic               enh_en,
  input  logic [BYTE_W-1:0]  ink_mask,
  input  logic               flash_phase,
  input  logic [BYTE_W-1:0]  paper_fallback,
  input  logic [BYTE_W-1:0]  pix_byte,
  input  logic [BYTE_W-1:0]  attr_byte,
  output logic [ADDR_W-1:0]  pix_addr,
  output logic [ADDR_W-1:0]  attr_addr,
  output logic [BYTE_W-1:0]  color_idx
);
  dec_ctl_t ctl_d;

  always_comb begin
    ctl_d.bit_sel  = beam_x[SEL_W-1:0];
    ctl_d.enh      = enh_en;
    ctl_d.ink_mask = ink_mask;
    ctl_d.phase    = flash_phase;
    ctl_d.fallback = paper_fallback;
  end

  cscr_addr_gen u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .x         (beam_x),
    .y         (beam_y),
    .alt       (scr_alt),
    .line_mode (line_attr),
    .pix_addr  (pix_addr),
    .attr_addr (attr_addr)
  );

  cscr_attr_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_d     (ctl_d),
    .pix_byte  (pix_byte),
    .attr_byte (attr_byte),
    .color_idx (color_idx)
  );
endmodule

// File: rtl/cscr_fetch_decode_chk.sv
module cscr_fetch_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  beam_x,
  input logic [7:0]  beam_y,
  input logic        scr_alt,
  input logic        line_attr,
  input logic        enh_en,
  input logic [7:0]  ink_mask,
  input logic        flash_phase,
  input logic [7:0]  paper_fallback,
  input logic [7:0]  pix_byte,
  input logic [7:0]  attr_byte,
  input logic [15:0] pix_addr,
  input logic [15:0] attr_addr,
  input logic [7:0]  color_idx
);
  p_pix_fields_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pix_addr[15:14] == 2'b01) &&
      (pix_addr[12:0] == {$past(beam_y[7:6]), $past(beam_y[2:0]),
                          $past(beam_y[5:3]), $past(beam_x[7:3])}));

  p_cell_attr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(line_attr)) |->
      (attr_addr[15:13] == pix_addr[15:13]) && (attr_addr[12:10] == 3'b110) &&
      (attr_addr[9:0] == {$past(beam_y[7:3]), $past(beam_x[7:3])}));

  p_alt_screen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(line_attr)) |-> (pix_addr[13] == $past(scr_alt)));

  p_line_attr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(line_attr)) |->
      (pix_addr[13] == 1'b0) && (attr_addr == (pix_addr | 16'h2000)));

  p_classic_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && !$past(enh_en, 2)) |-> (color_idx[7:4] == 4'h0));
endmodule

bind cscr_fetch_decode cscr_fetch_decode_chk u_chk (.*);

// File: tb/cscr_fetch_decode_tb.sv
`timescale 1ns/1ps
module cscr_fetch_decode_tb;
  logic        clk;
  logic        rst_n;
  logic [7:0]  beam_x, beam_y, ink_mask, paper_fallback, pix_byte, attr_byte;
  logic        scr_alt, line_attr, enh_en, flash_phase;
  logic [15:0] pix_addr, attr_addr;
  logic [7:0]  color_idx;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int unsigned lfsr = 32'h1ACE_B00C;

  typedef struct {
    bit v; int x; int y; int alt; int line; int enh; int mask; int ph; int fb; int pb; int ab;
  } stim_t;

  stim_t p1, p2, nx;

  cscr_fetch_decode u_dut (.*);

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic int rnd(int n);
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return int'(lfsr % n);
  endfunction

  function automatic int mem_rd(int a);
    return ((a * 97) ^ (a / 32) ^ (a / 4096 * 29)) % 256;
  endfunction

  function automatic int exp_pix(stim_t s);
    int alt_eff = s.line ? 0 : s.alt;
    return 16384 + alt_eff * 8192 + (s.y / 64) * 2048 + (s.y % 8) * 256 +
           ((s.y / 8) % 8) * 32 + s.x / 8;
  endfunction

  function automatic int exp_attr(stim_t s);
    if (s.line) return exp_pix(s) + 8192;
    return 22528 + s.alt * 8192 + (s.y / 8) * 32 + s.x / 8;
  endfunction

  function automatic int ink_count(int m);
    int k = 0;
    for (int i = 0; i < 8; i++) if ((m >> i) % 2 == 1) k++;
    if (k == 0) k = 8;
    return k;
  endfunction

  function automatic int exp_col(stim_t s);
    int lit = (s.pb >> (7 - s.x % 8)) % 2;
    if (s.enh == 0) begin
      int on = lit ^ ((s.ab / 128) & s.ph);
      return ((s.ab / 64) % 2) * 8 + (on ? s.ab % 8 : (s.ab / 8) % 8);
    end else begin
      int k = ink_count(s.mask);
      int p = 1 << k;
      if (lit) return s.ab % p;
      if (k == 8) return s.fb;
      return 128 + s.ab / p;
    end
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(stim_t s);
    beam_x = 8'(s.x); beam_y = 8'(s.y); scr_alt = s.alt[0]; line_attr = s.line[0];
    enh_en = s.enh[0]; ink_mask = 8'(s.mask); flash_phase = s.ph[0];
    paper_fallback = 8'(s.fb);
  endtask

  task automatic step(stim_t s);
    @(negedge clk);
    if (p1.v) begin
      check(p1.line ? "R4 pix" : (p1.alt ? "R3 pix" : "R1 pix"), int'(pix_addr), exp_pix(p1));
      check(p1.line ? "R4 attr" : (p1.alt ? "R3 attr" : "R2 attr"), int'(attr_addr), exp_attr(p1));
    end
    if (p2.v) begin
      string tag;
      if (p2.enh == 0) tag = ((p2.ab / 128) & p2.ph) ? "R5 R7 flash" : "R5 R6 classic";
      else if (ink_count(p2.mask) == 8)
        tag = (p2.mask == 0) ? "R11 zero mask" : "R10 fallback";
      else tag = "R8 R9 enhanced";
      check(tag, int'(color_idx), exp_col(p2));
    end
    if (p1.v) begin
      p1.pb = mem_rd(exp_pix(p1));
      p1.ab = mem_rd(exp_attr(p1));
      pix_byte  = 8'(p1.pb);
      attr_byte = 8'(p1.ab);
    end
    p2 = p1;
    p1 = s;
    drive(s);
  endtask

  function automatic stim_t mk(int x, int y, int alt, int line, int enh, int mask, int ph, int fb);
    stim_t s;
    s.v = 1; s.x = x; s.y = y; s.alt = alt; s.line = line; s.enh = enh;
    s.mask = mask; s.ph = ph; s.fb = fb; s.pb = 0; s.ab = 0;
    return s;
  endfunction

  initial begin
    int masks[7] = '{0, 255, 1, 7, 63, 127, 15};
    rst_n = 0;
    p1.v = 0; p2.v = 0;
    pix_byte = 0; attr_byte = 0;
    drive(mk(0, 0, 0, 0, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
    // R12: outputs held at zero in reset
    check("R12 pix", int'(pix_addr), 0);
    check("R12 attr", int'(attr_addr), 0);
    check("R12 color", int'(color_idx), 0);
    rst_n = 1;
    // directed corners
    step(mk(0, 0, 0, 0, 0, 0, 0, 0));
    step(mk(255, 191, 0, 0, 0, 0, 1, 0));
    step(mk(255, 191, 1, 0, 0, 0, 0, 0));
    step(mk(9, 77, 1, 1, 0, 0, 1, 0));
    step(mk(130, 64, 0, 1, 1, 0, 0, 8'h3C));
    step(mk(7, 127, 1, 0, 1, 255, 1, 8'hA5));
    step(mk(64, 8, 0, 0, 1, 7, 1, 0));
    step(mk(200, 190, 0, 0, 1, 63, 0, 0));
    // randomized sweep
    for (int i = 0; i < 4000; i++) begin
      step(mk(rnd(256), rnd(192), rnd(2), rnd(4) == 0 ? 1 : 0, rnd(2),
              masks[rnd(7)], rnd(2), rnd(256)));
    end
    step(mk(0, 0, 0, 0, 0, 0, 0, 0));
    step(mk(0, 0, 0, 0, 0, 0, 0, 0));
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule